// File: doc/BRIEF.md
# I2C Controller Status Register

This block holds the eight status flags that an I2C bus controller exposes to software. The bus engine reports what happens on the wire as single-cycle event pulses: a start it generated, a start or stop it detected, a lost arbitration, the eighth-clock sample of an incoming address, an address match, a direction report and an acknowledge report. The block turns these pulses into flags. Each flag has its own events that set it and its own events that clear it. The packed byte is presented on `status_o` every cycle.

Three control inputs shape the flags. The enable input forces every flag to zero while it is low. The exit-communication command drops the controller out of the current transfer. The wakeup-enable input freezes the byte from the cycle in which it falls until the next detected start or stop. A read strobe marks a byte read of the register. A byte read is the only action that clears the arbitration flag.

The bit layout of `status_o`:
- bit 7: master
- bit 6: arbitration lost
- bit 5: reserved-address (extension) code
- bit 4: address match
- bit 3: transmit direction
- bit 2: acknowledge
- bit 1: start seen
- bit 0: stop seen

Top module: `i2c_status_reg`

## Requirements
- R1: After reset `status_o` is 0x00. The bit positions are: 7 master, 6 arbitration lost, 5 extension code, 4 address match, 3 transmit, 2 acknowledge, 1 start seen, 0 stop seen.
- R2: Bit 7 sets on `start_gen_i`. It clears on `stop_det_i`, on `arb_lost_i` or on `exit_i`.
- R3: Bit 6 sets on `arb_lost_i` and clears on `rd_i`. The clear shows from the cycle after the strobe, so during the read cycle the byte still reports 1.
- R4: On `addr8_i`, bit 5 sets when `addr_hi_i` (the upper four address bits) is 4'b0000 or 4'b1111. It clears on `start_det_i`, on `stop_det_i` or on `exit_i`.
- R5: Bit 4 sets on `match_i`.
  - Bit 3 loads `dir_tx_i` on `dir_ev_i`.
  - Bit 2 loads `ack_val_i` on `ack_ev_i`.
  - Bits 4, 3 and 2 all clear on `start_det_i` or `stop_det_i`.
  - Bits 4 and 3 also clear on `exit_i`.
- R6: Bit 1 sets on `start_det_i` and clears on `stop_det_i`. Bit 0 sets on `stop_det_i` and clears on `start_det_i`.
- R7: When a set event and a clear event for the same flag arrive in the same cycle, the flag ends up set.
- R8: While `en_i` is 0, every flag is 0 on the next cycle and every event is ignored. A fall of `en_i` therefore clears all flags.
- R9: The byte holds its value from the cycle in which `wake_en_i` falls from 1 to 0 until a cycle carrying `start_det_i` or `stop_det_i`. The events of that releasing cycle are applied.
- R10: No input other than `rd_i` (or a low `en_i`) clears bit 6. In particular, `exit_i` and bus events leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Controller enable level |
| exit_i | input | 1 | Exit-communication command pulse |
| wake_en_i | input | 1 | Wakeup-enable level |
| rd_i | input | 1 | Byte read strobe of the status register |
| start_gen_i | input | 1 | Controller generated a start |
| start_det_i | input | 1 | Start condition detected |
| stop_det_i | input | 1 | Stop condition detected |
| arb_lost_i | input | 1 | Arbitration lost |
| addr8_i | input | 1 | Eighth-clock rising edge of the address byte |
| addr_hi_i | input | 4 | Upper four bits of the received address |
| match_i | input | 1 | Address match pulse |
| dir_ev_i | input | 1 | Direction report pulse |
| dir_tx_i | input | 1 | Direction value, 1 = transmit |
| ack_ev_i | input | 1 | Acknowledge report pulse |
| ack_val_i | input | 1 | Acknowledge value, 1 = acknowledged |
| status_o | output | 8 | Packed status byte |

## Verification
The extension-code logic is swept over all sixteen upper-nibble values. This separates the two reserved codes from their near neighbours 0001 and 1110. Each flag is driven through its set event and then through each of its clear events in turn, so a clear wired to the wrong event shows up as a wrong byte.

Several patterns put conflicting events in the same cycle to confirm that the set wins:
- arbitration loss together with a read;
- a generated start together with a stop;
- a match together with a stop.

A read is checked both during its own cycle and afterwards. The freeze window is opened by a falling wakeup-enable and closed by a detected stop, which shows both that events inside the window are discarded and that the releasing event takes effect.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

   localparam int STAT_W  = 8;
   localparam int NIB_W   = 4;

   localparam int B_SPD   = 0;
   localparam int B_STD   = 1;
   localparam int B_ACK   = 2;
   localparam int B_DIR   = 3;
   localparam int B_MATCH = 4;
   localparam int B_EXT   = 5;
   localparam int B_ARB   = 6;
   localparam int B_MST   = 7;

   typedef struct packed {
      logic start_gen;
      logic start_det;
      logic stop_det;
      logic arb_lost;
      logic addr8;
      logic match;
      logic dir_ev;
      logic dir_tx;
      logic ack_ev;
      logic ack_val;
      logic exit_cmd;
      logic rd;
   } bus_ev_t;

endpackage

// File: rtl/i2cs_fall.sv
module i2cs_fall #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic fall_o
);
   logic d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) d_q <= RST_VAL;
      else        d_q <= d_i;
   end

   assign fall_o = d_q & ~d_i;

   // the edge is reported one cycle late if the level is sampled wrongly
   p_fall_follows_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      d_i |=> (fall_o == !d_i));

endmodule

// File: rtl/i2cs_extcode.sv
module i2cs_extcode #(
   parameter int NIB_W      = 4,
   parameter bit MATCH_LOW  = 1'b1,
   parameter bit MATCH_HIGH = 1'b1
) (
   input  logic [NIB_W-1:0] nib_i,
   output logic             hit_o
);
   localparam logic [NIB_W-1:0] ALL_ZERO = '0;
   localparam logic [NIB_W-1:0] ALL_ONE  = '1;

   if (NIB_W < 1) begin : g_bad_width
      $error("i2cs_extcode: NIB_W must be at least 1");
   end

   logic low_hit, high_hit;

   if (MATCH_LOW) begin : g_low
      assign low_hit = (nib_i == ALL_ZERO);
   end else begin : g_no_low
      assign low_hit = 1'b0;
   end

   if (MATCH_HIGH) begin : g_high
      assign high_hit = (nib_i == ALL_ONE);
   end else begin : g_no_high
      assign high_hit = 1'b0;
   end

   assign hit_o = low_hit | high_hit;

   always_comb begin
      p_hit_is_reserved_r4: assert (!hit_o || nib_i == ALL_ZERO || nib_i == ALL_ONE);
   end

endmodule

// File: rtl/i2cs_flag.sv
module i2cs_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic zero_i,
   input  logic hold_i,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_q <= 1'b0;
      else if (zero_i) q_q <= 1'b0;
      else if (hold_i) q_q <= q_q;
      else if (set_i)  q_q <= 1'b1;
      else if (clr_i)  q_q <= 1'b0;
   end

   assign q_o = q_q;

   p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!zero_i && !hold_i && set_i) |=> q_o);

   p_clear_applies_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!zero_i && !hold_i && !set_i && clr_i) |=> !q_o);

   p_zero_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
      zero_i |=> !q_o);

   p_hold_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!zero_i && hold_i) |=> $stable(q_o));

endmodule

// File: rtl/i2c_status_reg.sv
module i2c_status_reg
   import i2cs_pkg::*;
#(
   parameter int  ADDR_HI_W   = NIB_W,
   parameter bit  EXT_LOW     = 1'b1,
   parameter bit  EXT_HIGH    = 1'b1,
   parameter bit  WAKE_FREEZE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en_i,
   input  logic                 exit_i,
   input  logic                 wake_en_i,
   input  logic                 rd_i,
   input  logic                 start_gen_i,
   input  logic                 start_det_i,
   input  logic                 stop_det_i,
   input  logic                 arb_lost_i,
   input  logic                 addr8_i,
   input  logic [ADDR_HI_W-1:0] addr_hi_i,
   input  logic                 match_i,
   input  logic                 dir_ev_i,
   input  logic                 dir_tx_i,
   input  logic                 ack_ev_i,
   input  logic                 ack_val_i,
   output logic [STAT_W-1:0]    status_o
);
   localparam int NFLAG = STAT_W;

   if (STAT_W != 8) begin : g_bad_stat
      $error("i2c_status_reg: the status byte must be 8 bits wide");
   end
   if (ADDR_HI_W != NIB_W) begin : g_bad_addr
      $error("i2c_status_reg: ADDR_HI_W must equal the nibble width");
   end

   bus_ev_t ev;
   always_comb begin
      ev.start_gen = start_gen_i;
      ev.start_det = start_det_i;
      ev.stop_det  = stop_det_i;
      ev.arb_lost  = arb_lost_i;
      ev.addr8     = addr8_i;
      ev.match     = match_i;
      ev.dir_ev    = dir_ev_i;
      ev.dir_tx    = dir_tx_i;
      ev.ack_ev    = ack_ev_i;
      ev.ack_val   = ack_val_i;
      ev.exit_cmd  = exit_i;
      ev.rd        = rd_i;
   end

   // reserved address classification
   logic ext_hit;
   i2cs_extcode #(
      .NIB_W     (ADDR_HI_W),
      .MATCH_LOW (EXT_LOW),
      .MATCH_HIGH(EXT_HIGH)
   ) u_ext (
      .nib_i(addr_hi_i),
      .hit_o(ext_hit)
   );

   // freeze window after wakeup-enable falls
   logic cond_det;
   logic hold;
   assign cond_det = ev.start_det | ev.stop_det;

   if (WAKE_FREEZE) begin : g_freeze
      logic wk_fall;
      logic frozen_q;

      i2cs_fall #(.RST_VAL(1'b0)) u_wk (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (wake_en_i),
         .fall_o(wk_fall)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 frozen_q <= 1'b0;
         else if (!en_i || cond_det) frozen_q <= 1'b0;
         else if (wk_fall)           frozen_q <= 1'b1;
      end

      assign hold = (frozen_q | wk_fall) & ~cond_det;
   end else begin : g_no_freeze
      logic unused_wk;
      assign unused_wk = wake_en_i;
      assign hold      = 1'b0;
   end

   // per-flag set and clear events
   logic [NFLAG-1:0] set_v, clr_v, q_v;
   always_comb begin
      set_v = '0;
      clr_v = '0;

      set_v[B_MST]   = ev.start_gen;
      clr_v[B_MST]   = ev.stop_det | ev.arb_lost | ev.exit_cmd;

      set_v[B_ARB]   = ev.arb_lost;
      clr_v[B_ARB]   = ev.rd;

      set_v[B_EXT]   = ev.addr8 & ext_hit;
      clr_v[B_EXT]   = cond_det | ev.exit_cmd;

      set_v[B_MATCH] = ev.match;
      clr_v[B_MATCH] = cond_det | ev.exit_cmd;

      set_v[B_DIR]   = ev.dir_ev & ev.dir_tx;
      clr_v[B_DIR]   = (ev.dir_ev & ~ev.dir_tx) | cond_det | ev.exit_cmd;

      set_v[B_ACK]   = ev.ack_ev & ev.ack_val;
      clr_v[B_ACK]   = (ev.ack_ev & ~ev.ack_val) | cond_det;

      set_v[B_STD]   = ev.start_det;
      clr_v[B_STD]   = ev.stop_det;

      set_v[B_SPD]   = ev.stop_det;
      clr_v[B_SPD]   = ev.start_det;
   end

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      i2cs_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .zero_i(~en_i),
         .hold_i(hold),
         .set_i (set_v[i]),
         .clr_i (clr_v[i]),
         .q_o   (q_v[i])
      );
   end

   assign status_o = q_v;

   // checks against the port-level contract
   p_disabled_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (status_o == '0));

   p_mst_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !hold && start_gen_i) |=> status_o[B_MST]);

   p_arb_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !hold && rd_i && !arb_lost_i) |=> !status_o[B_ARB]);

   p_arb_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && status_o[B_ARB] && !rd_i) |=> status_o[B_ARB]);

   p_ext_on_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !hold && addr8_i && ext_hit) |=> status_o[B_EXT]);

   p_frozen_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && hold) |=> $stable(status_o));

   p_start_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && start_det_i && !stop_det_i) |=> (status_o[B_STD] && !status_o[B_SPD]));

endmodule

// File: tb/sim_i2c_status_reg.sv
module sim_i2c_status_reg;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_i = 1'b0, exit_i = 1'b0, wake_en_i = 1'b0, rd_i = 1'b0;
   logic       start_gen_i = 1'b0, start_det_i = 1'b0, stop_det_i = 1'b0;
   logic       arb_lost_i = 1'b0, addr8_i = 1'b0, match_i = 1'b0;
   logic       dir_ev_i = 1'b0, dir_tx_i = 1'b0, ack_ev_i = 1'b0, ack_val_i = 1'b0;
   logic [3:0] addr_hi_i = 4'h0;
   logic [7:0] status_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   i2c_status_reg u0 (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .exit_i(exit_i),
      .wake_en_i(wake_en_i), .rd_i(rd_i), .start_gen_i(start_gen_i),
      .start_det_i(start_det_i), .stop_det_i(stop_det_i),
      .arb_lost_i(arb_lost_i), .addr8_i(addr8_i), .addr_hi_i(addr_hi_i),
      .match_i(match_i), .dir_ev_i(dir_ev_i), .dir_tx_i(dir_tx_i),
      .ack_ev_i(ack_ev_i), .ack_val_i(ack_val_i), .status_o(status_o)
   );

   task automatic chk(input string req, input logic [7:0] exp);
      n_chk++;
      if (status_o !== exp) begin
         n_fail++;
         $display("FAIL %s: status actual %02h expected %02h", req, status_o, exp);
      end
   endtask

   // one clock edge, then drop all pulses well away from the edge
   task automatic tick();
      @(posedge clk);
      #2;
      exit_i = 0; rd_i = 0; start_gen_i = 0; start_det_i = 0; stop_det_i = 0;
      arb_lost_i = 0; addr8_i = 0; match_i = 0; dir_ev_i = 0; ack_ev_i = 0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk("R1 reset value", 8'h00);
      rst_n = 1;
      tick();
      chk("R1 after reset release", 8'h00);

      // R8: events ignored while disabled
      start_gen_i = 1; arb_lost_i = 1; tick();
      chk("R8 disabled ignores events", 8'h00);
      en_i = 1; tick();

      // R2 master flag
      start_gen_i = 1; tick(); chk("R2 set on start_gen", 8'h80);
      stop_det_i = 1;  tick(); chk("R2 clear on stop", 8'h01);
      start_gen_i = 1; tick(); chk("R2 set again", 8'h81);
      exit_i = 1;      tick(); chk("R2 clear on exit", 8'h01);
      start_gen_i = 1; tick();
      arb_lost_i = 1;  tick(); chk("R2 clear on arb loss, R3 set", 8'h41);

      // R3 read-to-clear
      rd_i = 1; #1; chk("R3 read cycle still reports", 8'h41);
      tick(); chk("R3 cleared after read", 8'h01);

      // R10 only read clears arbitration flag
      arb_lost_i = 1;  tick(); chk("R3 set", 8'h41);
      exit_i = 1;      tick(); chk("R10 exit keeps arb", 8'h41);
      start_det_i = 1; tick(); chk("R10 start keeps arb, R6", 8'h42);
      stop_det_i = 1;  tick(); chk("R10 stop keeps arb, R6", 8'h41);
      rd_i = 1;        tick(); chk("R10 read clears", 8'h01);

      // R7 set wins
      arb_lost_i = 1; rd_i = 1; tick(); chk("R7 arb set beats read", 8'h41);
      rd_i = 1; tick(); chk("R7 read later clears", 8'h01);
      start_gen_i = 1; stop_det_i = 1; tick(); chk("R7 start_gen beats stop", 8'h81);
      exit_i = 1; tick(); chk("R2 exit", 8'h01);

      // R4 sweep of upper nibble
      for (int n = 0; n < 16; n++) begin
         logic [7:0] e;
         start_det_i = 1; tick(); chk("R6 start seen", 8'h02);
         addr_hi_i = n[3:0]; addr8_i = 1; tick();
         e = ((n == 0) || (n == 15)) ? 8'h22 : 8'h02;
         chk($sformatf("R4 nibble %0d", n), e);
         stop_det_i = 1; tick(); chk("R4 clear on stop", 8'h01);
      end
      addr_hi_i = 4'hF; addr8_i = 1; tick(); chk("R4 set from stop state", 8'h21);
      start_det_i = 1; tick(); chk("R4 clear on start", 8'h02);
      addr8_i = 1; tick(); chk("R4 set", 8'h22);
      exit_i = 1;  tick(); chk("R4 clear on exit", 8'h02);

      // R5 match, direction, acknowledge
      match_i = 1; tick(); chk("R5 match", 8'h12);
      dir_ev_i = 1; dir_tx_i = 1; tick(); chk("R5 transmit", 8'h1A);
      ack_ev_i = 1; ack_val_i = 1; tick(); chk("R5 ack", 8'h1E);
      dir_ev_i = 1; dir_tx_i = 0; tick(); chk("R5 receive", 8'h16);
      ack_ev_i = 1; ack_val_i = 0; tick(); chk("R5 nack", 8'h12);
      dir_ev_i = 1; dir_tx_i = 1; ack_ev_i = 1; ack_val_i = 1; tick();
      exit_i = 1; tick(); chk("R5 exit keeps ack only", 8'h06);
      match_i = 1; dir_ev_i = 1; tick(); chk("R5 reload", 8'h1E);
      start_det_i = 1; tick(); chk("R5 start clears", 8'h02);

      // R9 wakeup freeze
      wake_en_i = 1; tick(); chk("R9 wake on no effect", 8'h02);
      wake_en_i = 0; match_i = 1; tick(); chk("R9 frozen at fall", 8'h02);
      match_i = 1;    tick(); chk("R9 frozen match", 8'h02);
      arb_lost_i = 1; tick(); chk("R9 frozen arb", 8'h02);
      stop_det_i = 1; match_i = 1; tick(); chk("R9 released by stop", 8'h11);
      arb_lost_i = 1; tick(); chk("R9 updates resume", 8'h51);
      rd_i = 1; tick(); chk("R3 read after release", 8'h11);

      // R8 enable fall
      start_gen_i = 1; tick(); chk("R2 set", 8'h91);
      en_i = 0; tick(); chk("R8 enable fall clears", 8'h00);
      arb_lost_i = 1; match_i = 1; tick(); chk("R8 disabled", 8'h00);
      en_i = 1; tick(); chk("R8 re-enabled empty", 8'h00);
      start_gen_i = 1; tick(); chk("R8 works again", 8'h80);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule